// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel 8-bit voltage converter. A host shifts in command words over three serial pins (a bit clock, a data line and a framing strobe) plus a separate update strobe. Each command carries a two-bit channel number, a span bit and an eight-bit code. The block keeps two nine-bit registers per channel: a staging register written by commands, and a drive register that feeds the converter. The span bit selects a full scale of one times the reference (0) or two times the reference (1). The nominal output is Vref × CODE/256 × (1 + span).

All logic runs on a fast system clock. The four pins each pass through a two-stage synchroniser, and edges are found from the synchronised levels. The system clock must be at least eight times the highest bit-clock rate, and every pin level must stay stable for at least three system cycles.

A small state machine tracks framing. Its states and transitions are:
- ST_IDLE: the framing strobe is low and bit-clock edges are ignored. It moves to ST_SHIFT when the strobe is seen high.
- ST_SHIFT: each bit-clock falling edge shifts one bit in. It moves to ST_COMMIT when the strobe falls.
- ST_COMMIT: lasts one cycle and writes the decoded command. It returns to ST_SHIFT if the strobe is already high again, and to ST_IDLE otherwise.

Top module: `quad_dac_serial_if`

## Requirements
- R1: A command is 11 bits sent most significant first: channel[1], channel[0], span, code[7] down to code[0]. It is stored as the 9-bit word {span, code}.
- R2: Bits are taken only on falling edges of `ser_clk_i` while `load_i` is high. Bit-clock edges while `load_i` is low leave the shift register unchanged.
- R3: Any number of bits may be shifted in during a frame. Only the 11 most recent bits form the command.
- R4: Channel number 0 drives `chan_words_o[8:0]`, 1 drives [17:9], 2 drives [26:18] and 3 drives [35:27].
- R5: A falling edge of `load_i` writes the command into the addressed staging register. While `upd_i` is low, the addressed drive register takes the same word at the same time. The other channels are unchanged.
- R6: While `upd_i` is high, a `load_i` falling edge changes only a staging register. `chan_words_o` holds its value.
- R7: A falling edge of `upd_i` copies all four staging registers into the drive registers in one cycle.
- R8: Reset clears both registers of every channel, the shift register and the state machine. A frame shorter than 11 bits after reset therefore has zeros in its upper bits.
- R9: If a bit-clock falling edge and a `load_i` falling edge are seen in the same system cycle, the bit is shifted in before the command is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock; bits are taken on its falling edge |
| ser_dat_i | input | 1 | Serial data |
| load_i | input | 1 | Frame strobe; its falling edge commits the command |
| upd_i | input | 1 | Update strobe; low means transparent, falling edge copies all channels |
| chan_words_o | output | 36 | Four {span, code} drive words, channel 0 in the low bits |

## Verification
On every cycle, the assertions check four things:
- A strobe fall always produces a commit.
- Staging registers change only on a commit.
- Drive registers change only on a commit or an update fall.
- A transparent commit lands the decoded word in exactly the addressed drive slot, and an update fall copies the staging contents.

Some behaviours appear only at the pins, so only the bench scenarios show them:
- the bit order and channel decode across a sweep of every channel, both spans and several codes;
- truncation to the last eleven bits;
- bit-clock edges ignored while the strobe is low;
- zero padding after reset;
- a final bit that arrives together with the strobe fall.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/qdac_fall_det.sv
module qdac_fall_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/qdac_cmd_fsm.sv
module qdac_cmd_fsm
    import qdac_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int WORD_W = 9,
    localparam int FRAME_W = ADDR_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_fall_i,
    input  logic              dat_lvl_i,
    input  logic              load_lvl_i,
    input  logic              load_fall_i,
    output logic              commit_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] word_o
);
    frame_state_t       state_q, state_d;
    logic [FRAME_W-1:0] shreg_q;
    logic               shift_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load_lvl_i)  state_d = ST_SHIFT;
            ST_SHIFT:  if (load_fall_i) state_d = ST_COMMIT;
            ST_COMMIT: state_d = load_lvl_i ? ST_SHIFT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit_o = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SHIFT:  shift_en = bit_fall_i;
            ST_COMMIT: commit_o = 1'b1;
            default:   ;
        endcase
    end

    // a bit landing with the strobe fall is shifted before ST_COMMIT decodes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        shreg_q <= '0;
        else if (shift_en) shreg_q <= {shreg_q[FRAME_W-2:0], dat_lvl_i};
    end

    assign addr_o = shreg_q[FRAME_W-1 -: ADDR_W];
    assign word_o = shreg_q[WORD_W-1:0];
endmodule

// File: rtl/qdac_latch_bank.sv
module qdac_latch_bank #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 9,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int FLAT_W = NUM_CH * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              upd_lvl_i,
    input  logic              upd_fall_i,
    output logic [FLAT_W-1:0] stage_o,
    output logic [FLAT_W-1:0] drive_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic              sel;
        logic [WORD_W-1:0] stage_q, drive_q;

        assign sel = commit_i && (addr_i == ADDR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
                drive_q <= '0;
            end else begin
                if (sel) stage_q <= word_i;
                if (sel && !upd_lvl_i) drive_q <= word_i;
                else if (upd_fall_i)   drive_q <= stage_q;
            end
        end

        assign stage_o[g*WORD_W +: WORD_W] = stage_q;
        assign drive_o[g*WORD_W +: WORD_W] = drive_q;
    end
endmodule

// File: rtl/quad_dac_serial_if.sv
module quad_dac_serial_if #(
    parameter int NUM_CH      = 4,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W = CODE_W + 1,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int FLAT_W = NUM_CH * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              load_i,
    input  logic              upd_i,
    output logic [FLAT_W-1:0] chan_words_o
);
    logic [3:0]        pin_lvl;
    logic [2:0]        pin_fall;
    logic              bit_fall, load_fall, upd_fall;
    logic              dat_lvl, load_lvl, upd_lvl;
    logic              cmd_commit;
    logic [ADDR_W-1:0] cmd_addr;
    logic [WORD_W-1:0] cmd_word;
    logic [FLAT_W-1:0] stage_flat;

    qdac_sync #(.W(4), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_i({ser_dat_i, upd_i, load_i, ser_clk_i}),
        .lvl_o(pin_lvl)
    );

    qdac_fall_det #(.W(3)) i_fall (
        .clk(clk), .rst_n(rst_n),
        .lvl_i(pin_lvl[2:0]),
        .fall_o(pin_fall)
    );

    assign bit_fall  = pin_fall[0];
    assign load_fall = pin_fall[1];
    assign upd_fall  = pin_fall[2];
    assign load_lvl  = pin_lvl[1];
    assign upd_lvl   = pin_lvl[2];
    assign dat_lvl   = pin_lvl[3];

    qdac_cmd_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .bit_fall_i(bit_fall), .dat_lvl_i(dat_lvl),
        .load_lvl_i(load_lvl), .load_fall_i(load_fall),
        .commit_o(cmd_commit), .addr_o(cmd_addr), .word_o(cmd_word)
    );

    qdac_latch_bank #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .commit_i(cmd_commit), .addr_i(cmd_addr), .word_i(cmd_word),
        .upd_lvl_i(upd_lvl), .upd_fall_i(upd_fall),
        .stage_o(stage_flat), .drive_o(chan_words_o)
    );
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 9,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int FLAT_W = NUM_CH * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_fall,
    input logic              upd_lvl,
    input logic              upd_fall,
    input logic              commit,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] word,
    input logic [FLAT_W-1:0] stage,
    input logic [FLAT_W-1:0] drive
);
    assert_commit_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> commit);

    assert_stage_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(stage));

    assert_drive_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !upd_fall) |=> $stable(drive));

    assert_transparent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !upd_lvl) |=> (drive[WORD_W*$past(addr) +: WORD_W] == $past(word)));

    assert_update_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fall && !commit) |=> (drive == $past(stage)));
endmodule

bind quad_dac_serial_if qdac_checker #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .load_fall(load_fall), .upd_lvl(upd_lvl),
    .upd_fall(upd_fall), .commit(cmd_commit), .addr(cmd_addr), .word(cmd_word),
    .stage(stage_flat), .drive(chan_words_o)
);

// File: tb/test_quad_dac_serial_if.sv
module test_quad_dac_serial_if;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, load = 1'b0, upd = 1'b0;
    logic [35:0] words;
    int errors = 0, checks = 0;
    bit done = 1'b0;
    logic [8:0] exp_in [4];
    logic [8:0] exp_out[4];

    always #2 clk = ~clk;

    quad_dac_serial_if i_quad_dac_serial_if (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .load_i(load), .upd_i(upd), .chan_words_o(words)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        for (int ch = 0; ch < 4; ch++) begin
            checks++;
            if (words[9*ch +: 9] !== exp_out[ch]) begin
                errors++;
                $display("FAIL %s ch%0d actual=%h expected=%h", req, ch,
                         words[9*ch +: 9], exp_out[ch]);
            end
        end
    endtask

    task automatic put_bit(input logic b);
        ser_dat = b; idle(8);
        ser_clk = 1'b1; idle(8);
        ser_clk = 1'b0; idle(8);
    endtask

    task automatic put_frame(input int a, input logic r, input logic [7:0] c);
        logic [10:0] f;
        f = {a[1:0], r, c};
        for (int i = 10; i >= 0; i--) put_bit(f[i]);
    endtask

    task automatic note_cmd(input int a, input logic r, input logic [7:0] c);
        exp_in[a] = {r, c};
        if (!upd) exp_out[a] = {r, c};
    endtask

    task automatic send(input int a, input logic r, input logic [7:0] c);
        load = 1'b1; idle(8);
        put_frame(a, r, c);
        load = 1'b0; idle(16);
        note_cmd(a, r, c);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; idle(4); rst_n = 1'b1; idle(4);
        for (int ch = 0; ch < 4; ch++) begin exp_in[ch] = '0; exp_out[ch] = '0; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [6];
        logic [10:0] f;
        codes = '{8'h00, 8'h01, 8'h55, 8'hAA, 8'h80, 8'hFF};
        do_reset();
        check_all("R8 reset");

        // R1 R4 R5: sweep channel, span and code in transparent mode
        for (int a = 0; a < 4; a++)
            for (int r = 0; r < 2; r++)
                for (int k = 0; k < 6; k++) begin
                    send(a, r[0], codes[k] ^ 8'(a * 17));
                    check_all("R1_R4_R5 sweep");
                end

        // R3: leading extra bits are discarded
        load = 1'b1; idle(8);
        put_bit(1); put_bit(1); put_bit(0); put_bit(1); put_bit(1);
        put_frame(1, 1'b0, 8'h9A);
        load = 1'b0; idle(16);
        note_cmd(1, 1'b0, 8'h9A);
        check_all("R3 last eleven");

        // R2: bit clock edges while strobe low are ignored; re-commit repeats last frame
        put_frame(3, 1'b1, 8'h77);
        load = 1'b1; idle(8); load = 1'b0; idle(16);
        check_all("R2 ignore while low");

        // R9: final bit and strobe fall in the same cycle
        f = {2'd2, 1'b1, 8'h3C};
        load = 1'b1; idle(8);
        for (int i = 10; i >= 1; i--) put_bit(f[i]);
        ser_dat = f[0]; idle(8);
        ser_clk = 1'b1; idle(8);
        ser_clk = 1'b0; load = 1'b0; idle(16);
        note_cmd(2, 1'b1, 8'h3C);
        check_all("R9 shift before commit");

        // R6: held drive while update high
        upd = 1'b1; idle(8);
        send(0, 1'b1, 8'h12);
        send(1, 1'b0, 8'hE4);
        send(2, 1'b0, 8'h00);
        send(3, 1'b1, 8'hC3);
        check_all("R6 hold while update high");

        // R7: update fall copies all channels
        upd = 1'b0; idle(16);
        for (int ch = 0; ch < 4; ch++) exp_out[ch] = exp_in[ch];
        check_all("R7 simultaneous copy");

        // R8: short frame after reset is zero padded
        do_reset();
        check_all("R8 reset again");
        load = 1'b1; idle(8);
        put_bit(1); put_bit(0); put_bit(1);
        load = 1'b0; idle(16);
        note_cmd(0, 1'b0, 8'h05);
        check_all("R8 zero padded");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule